// File: doc/BRIEF.md
# Masked Interrupt Aggregator Registers

This block gathers interrupt requests from six on-chip sources into a pending register and gates them with a mask register. It drives one combined interrupt line into a two-bit processor cause field. Each source raises or drops its pending bit through a pair of strobes. A second cause bit follows a separate external interrupt line that has its own assert and deassert strobes.

Software reaches the block through a word-addressed register bus. The bus has a write strobe, a read strobe, a byte offset, write data and a four-bit byte-lane mask. Software never writes the mask bits or the three mode flags directly. Each one is driven by a clear/set command pair in the written word, and the clear wins when both bits are set. One command bit of a mode write acknowledges the pending interrupt of source 5. Reset is synchronous and active high, and it zeroes every register.

Top module: `intr_agg_regs`

## Requirements
- R1: A `src_raise[n]` pulse sets pending bit n at the next clock edge.
- R2: A `src_clear[n]` pulse clears pending bit n at the next clock edge. When raise and clear for the same source arrive in the same cycle, the bit ends up set.
- R3: `cause_o[0]` is 1 exactly when (pending AND mask) is nonzero. It is updated on the same clock edge as the registers it depends on.
- R4: A write to the mask register (word index 3) treats word bit 2n as "clear mask bit n" and bit 2n+1 as "set mask bit n", for n = 0..5. If both bits of a pair are 1, the mask bit is cleared. A pair of zeros leaves the mask bit unchanged.
- R5: A write to the mode register (word index 0) first loads word bits 9:0. The init flag is held at mode bit 8: word bit 7 then clears it, and otherwise word bit 8 sets it.
- R6: In a mode write, word bit 9 clears the test flag (mode bit 7), and otherwise word bit 10 sets it. Word bit 12 clears the memory-register flag (mode bit 9), and otherwise word bit 13 sets it.
- R7: A mode write with word bit 11 set clears pending bit 5 and re-evaluates `cause_o[0]` on the same edge. A `src_raise[5]` in the same cycle keeps the bit set.
- R8: `cause_o[1]` is set by an `ext_assert` pulse and cleared by an `ext_deassert` pulse at the next edge. Assert wins when both arrive in the same cycle.
- R9: The register is chosen by `bus_addr >> 2`: 0 selects mode, 1 scratch, 2 pending and 3 mask. A write to scratch first clears every bit of each byte whose lane bit is 1, then ORs in the full written word.
- R10: The pending register is read-only from the bus. A bus write to index 2 leaves it unchanged.
- R11: A read returns the selected register, zero-extended to 32 bits, on `bus_rdata` one cycle after `bus_rd`. `bus_rdata` holds its value when no read is made.
- R12: After reset, pending, mask, mode, scratch, `cause_o` and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset from the block base, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_lanes | input | 4 | Byte-lane mask applied by scratch writes |
| bus_rdata | output | 32 | Registered read data |
| src_raise | input | 6 | Per-source interrupt raise strobes |
| src_clear | input | 6 | Per-source interrupt clear strobes |
| ext_assert | input | 1 | External interrupt assert strobe |
| ext_deassert | input | 1 | External interrupt deassert strobe |
| cause_o | output | 2 | Processor cause field: bit 0 combined, bit 1 external |

## Verification
Every state change, whether from a strobe, a mask write or a mode write, shows at the ports exactly one edge after the cycle that carried the stimulus. `cause_o` changes on that edge, and `bus_rdata` carries the value the selected register held before that edge. The bench drives inputs at the falling edge and advances a behavioural model at the rising edge. It compares both outputs at the next falling edge, so each result is sampled in the first cycle it is due. A read issued in the cycle right after a write therefore shows the written value.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 6;
    localparam int MODE_W  = 10;
    localparam int LANES   = DATA_W / 8;
    localparam int ADDR_W  = 4;

    // stored flag positions inside the mode register
    localparam int FLAG_TEST = 7;
    localparam int FLAG_INIT = 8;
    localparam int FLAG_MEMR = 9;

    // command bit positions inside a mode write
    localparam int CMD_INIT_CLR = 7;
    localparam int CMD_INIT_SET = 8;
    localparam int CMD_TEST_CLR = 9;
    localparam int CMD_TEST_SET = 10;
    localparam int CMD_ACK      = 11;
    localparam int CMD_MEMR_CLR = 12;
    localparam int CMD_MEMR_SET = 13;

    localparam int ACK_SRC = 5;

    typedef enum logic [1:0] {
        REG_MODE    = 2'd0,
        REG_SCRATCH = 2'd1,
        REG_PEND    = 2'd2,
        REG_MASK    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
    } bus_req_t;

    function automatic logic flag_cmd(input logic cur, input logic clr, input logic set);
        if (clr)      return 1'b0;
        else if (set) return 1'b1;
        else          return cur;
    endfunction

    function automatic logic [MODE_W-1:0] mode_apply(input logic [DATA_W-1:0] w);
        logic [MODE_W-1:0] r;
        r = w[MODE_W-1:0];
        r[FLAG_INIT] = flag_cmd(r[FLAG_INIT], w[CMD_INIT_CLR], w[CMD_INIT_SET]);
        r[FLAG_TEST] = flag_cmd(r[FLAG_TEST], w[CMD_TEST_CLR], w[CMD_TEST_SET]);
        r[FLAG_MEMR] = flag_cmd(r[FLAG_MEMR], w[CMD_MEMR_CLR], w[CMD_MEMR_SET]);
        return r;
    endfunction

    function automatic logic [NUM_SRC-1:0] mask_apply(input logic [NUM_SRC-1:0] cur,
                                                      input logic [DATA_W-1:0]  w);
        logic [NUM_SRC-1:0] r;
        for (int n = 0; n < NUM_SRC; n++)
            r[n] = flag_cmd(cur[n], w[2*n], w[2*n+1]);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*8 +: 8] = {8{be[i]}};
        return r;
    endfunction

endpackage

// File: rtl/intr_pending.sv
module intr_pending
    import intr_agg_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int ACK_BIT = ACK_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] raise_i,
    input  logic [N_SRC-1:0] clear_i,
    input  logic             ack_i,
    output logic [N_SRC-1:0] pend_d_o,
    output logic [N_SRC-1:0] pend_q_o
);

    logic [N_SRC-1:0] ack_vec;

    always_comb begin
        ack_vec = '0;
        ack_vec[ACK_BIT] = ack_i;
    end

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
        // a raise overrides both the strobe clear and the mode acknowledge
        assign pend_d_o[gi] = raise_i[gi] | (pend_q_o[gi] & ~clear_i[gi] & ~ack_vec[gi]);

        always_ff @(posedge clk) begin
            if (rst) pend_q_o[gi] <= 1'b0;
            else     pend_q_o[gi] <= pend_d_o[gi];
        end

        a_r1_raise_sets: assert property (@(posedge clk) disable iff (rst)
            raise_i[gi] |=> pend_q_o[gi]);

        a_r2_clear_drops: assert property (@(posedge clk) disable iff (rst)
            (clear_i[gi] && !raise_i[gi]) |=> !pend_q_o[gi]);

        a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
            (!clear_i[gi] && !raise_i[gi] && !ack_vec[gi]) |=> $stable(pend_q_o[gi]));
    end

endmodule

// File: rtl/intr_ctrl_regs.sv
module intr_ctrl_regs
    import intr_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int DW    = DATA_W,
    parameter int MW    = MODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req_i,
    output logic             ack_o,
    output logic [N_SRC-1:0] mask_d_o,
    output logic [N_SRC-1:0] mask_q_o,
    output logic [MW-1:0]    mode_q_o,
    output logic [DW-1:0]    scratch_q_o
);

    logic          wr_mode, wr_mask, wr_scratch;
    logic [MW-1:0] mode_d;
    logic [DW-1:0] scratch_d;

    assign wr_mode    = req_i.wr && (req_i.sel == REG_MODE);
    assign wr_mask    = req_i.wr && (req_i.sel == REG_MASK);
    assign wr_scratch = req_i.wr && (req_i.sel == REG_SCRATCH);

    assign ack_o = wr_mode && req_i.wdata[CMD_ACK];

    always_comb begin
        mask_d_o  = wr_mask    ? mask_apply(mask_q_o, req_i.wdata) : mask_q_o;
        mode_d    = wr_mode    ? mode_apply(req_i.wdata)           : mode_q_o;
        scratch_d = wr_scratch ? ((scratch_q_o & ~lane_bits(req_i.lanes)) | req_i.wdata)
                               : scratch_q_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q_o    <= '0;
            mode_q_o    <= '0;
            scratch_q_o <= '0;
        end else begin
            mask_q_o    <= mask_d_o;
            mode_q_o    <= mode_d;
            scratch_q_o <= scratch_d;
        end
    end

    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && req_i.wdata[0]) |=> !mask_q_o[0]);

    a_r4_set_pair: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && !req_i.wdata[2] && req_i.wdata[3]) |=> mask_q_o[1]);

    a_r4_no_write_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_mask |=> $stable(mask_q_o));

    a_r5_init_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && req_i.wdata[CMD_INIT_CLR]) |=> !mode_q_o[FLAG_INIT]);

    a_r6_test_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && req_i.wdata[CMD_TEST_CLR]) |=> !mode_q_o[FLAG_TEST]);

    a_r6_memr_set: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && !req_i.wdata[CMD_MEMR_CLR] && req_i.wdata[CMD_MEMR_SET]) |=> mode_q_o[FLAG_MEMR]);

endmodule

// File: rtl/intr_cause_out.sv
module intr_cause_out
    import intr_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend_d_i,
    input  logic [N_SRC-1:0] mask_d_i,
    input  logic             ext_assert_i,
    input  logic             ext_deassert_i,
    output logic [1:0]       cause_o
);

    logic combined_d;
    logic ext_d;

    assign combined_d = |(pend_d_i & mask_d_i);
    assign ext_d      = ext_assert_i ? 1'b1 : (ext_deassert_i ? 1'b0 : cause_o[1]);

    always_ff @(posedge clk) begin
        if (rst) cause_o <= 2'b00;
        else     cause_o <= {ext_d, combined_d};
    end

    a_r8_ext_assert: assert property (@(posedge clk) disable iff (rst)
        ext_assert_i |=> cause_o[1]);

    a_r8_ext_deassert: assert property (@(posedge clk) disable iff (rst)
        (ext_deassert_i && !ext_assert_i) |=> !cause_o[1]);

endmodule

// File: rtl/intr_agg_regs.sv
module intr_agg_regs
    import intr_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int LW    = LANES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [LW-1:0] bus_lanes,
    output logic [DW-1:0] bus_rdata,
    input  logic [N_SRC-1:0] src_raise,
    input  logic [N_SRC-1:0] src_clear,
    input  logic          ext_assert,
    input  logic          ext_deassert,
    output logic [1:0]    cause_o
);

    bus_req_t            req;
    logic                ack;
    logic [N_SRC-1:0]    pend_d, pend_q, mask_d, mask_q;
    logic [MODE_W-1:0]   mode_q;
    logic [DW-1:0]       scratch_q;
    logic [DW-1:0]       rd_mux;

    always_comb begin
        req.wr    = bus_wr;
        req.rd    = bus_rd;
        req.sel   = reg_sel_e'(bus_addr[AW-1:2]);
        req.wdata = bus_wdata;
        req.lanes = bus_lanes;
    end

    intr_pending #(.N_SRC(N_SRC), .ACK_BIT(ACK_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .raise_i  (src_raise),
        .clear_i  (src_clear),
        .ack_i    (ack),
        .pend_d_o (pend_d),
        .pend_q_o (pend_q)
    );

    intr_ctrl_regs #(.N_SRC(N_SRC), .DW(DW), .MW(MODE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .ack_o       (ack),
        .mask_d_o    (mask_d),
        .mask_q_o    (mask_q),
        .mode_q_o    (mode_q),
        .scratch_q_o (scratch_q)
    );

    intr_cause_out #(.N_SRC(N_SRC)) u_cause (
        .clk            (clk),
        .rst            (rst),
        .pend_d_i       (pend_d),
        .mask_d_i       (mask_d),
        .ext_assert_i   (ext_assert),
        .ext_deassert_i (ext_deassert),
        .cause_o        (cause_o)
    );

    always_comb begin
        rd_mux = '0;
        unique case (req.sel)
            REG_MODE:    rd_mux[MODE_W-1:0] = mode_q;
            REG_SCRATCH: rd_mux             = scratch_q;
            REG_PEND:    rd_mux[N_SRC-1:0]  = pend_q;
            REG_MASK:    rd_mux[N_SRC-1:0]  = mask_q;
            default:     rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    a_r3_combined_line: assert property (@(posedge clk) disable iff (rst)
        cause_o[0] == (|(pend_q & mask_q)));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && req.sel == REG_MODE && bus_wdata[CMD_ACK] && !src_raise[ACK_SRC])
            |=> !pend_q[ACK_SRC]);

    a_r10_pend_readonly: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && req.sel == REG_PEND && src_raise == '0 && src_clear == '0)
            |=> $stable(pend_q));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_wr || bus_rd) |-> (bus_addr[1:0] == 2'b00));

endmodule

// File: tb/intr_agg_regs_test.sv
module intr_agg_regs_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_lanes;
    logic [31:0] bus_rdata;
    logic [5:0]  src_raise, src_clear;
    logic        ext_assert, ext_deassert;
    logic [1:0]  cause_o;

    always #4 clk = ~clk;

    intr_agg_regs uut (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_lanes(bus_lanes), .bus_rdata(bus_rdata),
        .src_raise(src_raise), .src_clear(src_clear),
        .ext_assert(ext_assert), .ext_deassert(ext_deassert),
        .cause_o(cause_o)
    );

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string tag = "R12";

    // behavioural reference state
    int unsigned m_pend, m_mask, m_mode, m_scr, m_rdata;
    int unsigned m_ext;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer than 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic int unsigned cmd(int unsigned cur, int unsigned w, int c, int s);
        if ((w >> c) & 1) return 0;
        if ((w >> s) & 1) return 1;
        return cur;
    endfunction

    task automatic model_reset();
        m_pend = 0; m_mask = 0; m_mode = 0; m_scr = 0; m_rdata = 0; m_ext = 0;
    endtask

    task automatic model_step();
        int unsigned sel, w, lm, np, nm, nd, ns;
        sel = bus_addr >> 2;
        w = bus_wdata;
        if (bus_rd) begin
            case (sel)
                0: m_rdata = m_mode;
                1: m_rdata = m_scr;
                2: m_rdata = m_pend;
                default: m_rdata = m_mask;
            endcase
        end
        np = m_pend & ~32'(src_clear);
        if (bus_wr && sel == 0 && w[11]) np = np & ~32'h20;
        np = np | 32'(src_raise);
        nm = m_mask; nd = m_mode; ns = m_scr;
        if (bus_wr && sel == 3) begin
            for (int n = 0; n < 6; n++) begin
                int unsigned b;
                b = cmd((m_mask >> n) & 1, w, 2*n, 2*n+1);
                nm = (nm & ~(32'd1 << n)) | (b << n);
            end
        end
        if (bus_wr && sel == 0) begin
            nd = w & 32'h3FF;
            nd = (nd & ~32'h100) | (cmd((nd >> 8) & 1, w, 7, 8) << 8);
            nd = (nd & ~32'h080) | (cmd((nd >> 7) & 1, w, 9, 10) << 7);
            nd = (nd & ~32'h200) | (cmd((nd >> 9) & 1, w, 12, 13) << 9);
        end
        if (bus_wr && sel == 1) begin
            lm = 0;
            for (int i = 0; i < 4; i++) if (bus_lanes[i]) lm = lm | (32'hFF << (8*i));
            ns = (m_scr & ~lm) | w;
        end
        if (ext_assert) m_ext = 1;
        else if (ext_deassert) m_ext = 0;
        m_pend = np; m_mask = nm; m_mode = nd; m_scr = ns;
    endtask

    task automatic compare();
        logic [1:0] exp_c;
        exp_c = {m_ext[0], ((m_pend & m_mask) != 0)};
        compared++;
        if (cause_o !== exp_c) begin
            mismatched++;
            $display("FAIL %s cause: actual %b expected %b", tag, cause_o, exp_c);
        end
        compared++;
        if (bus_rdata !== m_rdata) begin
            mismatched++;
            $display("FAIL %s rdata: actual %h expected %h", tag, bus_rdata, m_rdata);
        end
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; bus_lanes = 0;
        src_raise = 0; src_clear = 0; ext_assert = 0; ext_deassert = 0;
    endtask

    // one clock: inputs already driven at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic wr(input int sel, input logic [31:0] d, input logic [3:0] be = 4'h0);
        bus_wr = 1; bus_addr = 4'(sel << 2); bus_wdata = d; bus_lanes = be; tick();
    endtask

    task automatic rd(input int sel);
        bus_rd = 1; bus_addr = 4'(sel << 2); tick();
    endtask

    task automatic strobe(input logic [5:0] r, input logic [5:0] c);
        src_raise = r; src_clear = c; tick();
    endtask

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        tag = "R12";
        for (int s = 0; s < 4; s++) rd(s);

        tag = "R1"; strobe(6'b000101, 0); rd(2); strobe(6'b101000, 0); rd(2);
        tag = "R3"; wr(3, 32'h0000_0002); rd(3);
        tag = "R2"; strobe(0, 6'b000001); rd(2); strobe(6'b000010, 6'b000010); rd(2);
        strobe(0, 6'b111111); rd(2);
        tag = "R4"; wr(3, 32'h0000_0AAA); rd(3); wr(3, 32'h0000_0003); rd(3);
        wr(3, 32'h0000_0FFF); rd(3); wr(3, 32'h0000_0008); wr(3, 0); rd(3);
        tag = "R3"; strobe(6'b000100, 0); strobe(0, 6'b000100); wr(3, 32'h0000_0004); rd(3);
        tag = "R5"; wr(0, 32'h0000_0100); rd(0); wr(0, 32'h0000_0180); rd(0);
        wr(0, 32'h0000_007F); rd(0);
        tag = "R6"; wr(0, 32'h0000_0400); rd(0); wr(0, 32'h0000_0680); rd(0);
        wr(0, 32'h0000_2000); rd(0); wr(0, 32'h0000_3200); rd(0);
        tag = "R7"; wr(3, 32'h0000_0800); strobe(6'b100001, 0); wr(0, 32'h0000_0800); rd(2);
        strobe(6'b100000, 0); bus_wr = 1; bus_addr = 0; bus_wdata = 32'h800; src_raise = 6'b100000; tick();
        rd(2);
        tag = "R8"; ext_assert = 1; tick(); ext_deassert = 1; tick();
        ext_assert = 1; ext_deassert = 1; tick(); ext_deassert = 1; tick();
        tag = "R9"; wr(1, 32'hDEAD_BEEF, 4'hF); rd(1); wr(1, 32'h0000_0011, 4'b0011); rd(1);
        wr(1, 32'h0100_0000, 4'b0000); rd(1);
        tag = "R10"; strobe(6'b010010, 0); wr(2, 32'hFFFF_FFFF, 4'hF); rd(2); wr(2, 0, 4'hF); rd(2);
        tag = "R11"; rd(1); tick(); tick(); rd(3);

        tag = "R3";
        for (int k = 0; k < 400; k++) begin
            int unsigned pick;
            pick = $urandom % 8;
            src_raise = 6'($urandom) & 6'($urandom);
            src_clear = 6'($urandom) & 6'($urandom);
            ext_assert = ($urandom % 5) == 0;
            ext_deassert = ($urandom % 5) == 0;
            if (pick < 3) begin
                bus_wr = 1; bus_addr = 4'(($urandom % 4) << 2);
                bus_wdata = $urandom; bus_lanes = 4'($urandom);
            end else if (pick < 6) begin
                bus_rd = 1; bus_addr = 4'(($urandom % 4) << 2);
            end
            tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule